// File: doc/BRIEF.md
# GPIO Line Interrupt Unit

This block turns eight general-purpose input pins into interrupt requests. Each line is set up on its own through a small byte-wide register set. One bit picks level or edge sensing. A second bit picks the active sense: high or rising, or low or falling. Further bits enable the line's request and turn on an input filter. Edge events are held in sticky flags until software acknowledges them by writing ones. The unmasked and the masked views of the line states can both be read back.

Pins first cross a two-stage synchronizer. When filtering is enabled, a new level passes only after it has been stable for a set number of cycles. Edge sensing compares the qualified input with its value one cycle earlier, so changing the sense bit alone never creates an event. Software can therefore watch both edges by flipping the sense bit after each acknowledge. The block drives one request per line and one combined request.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is asserted, every writable register and every edge flag is 0 and all request outputs are low. Out of reset with pins low, the unmasked state reads 0xFF, because mode 0 with sense 0 is active-low level.
- R2: Register select (addr_i): 0x00 mode (0 level, 1 edge), 0x04 sense (0 low/falling, 1 high/rising), 0x08 acknowledge (write-only, reads 0), 0x0C enable, 0x10 masked state, 0x14 unmasked state, 0x18 filter enable. Bit n of each register belongs to line n. A write takes effect at the clock edge where wr_i is high. Reads are combinational.
- R3: In level mode the unmasked bit equals the qualified input when sense is 1 and its inverse when sense is 0. It is not latched. An unfiltered pin change shows after the second clock edge.
- R4: In edge mode a change of the qualified input in the selected direction sets a sticky flag. For an unfiltered pin the flag is visible after the third clock edge. Without a write the flag never clears.
- R5: Writing to the acknowledge register clears the edge flag of each line written with 1 and leaves lines written with 0 unchanged. An edge detected in the same cycle keeps its flag set.
- R6: The masked state is the unmasked state ANDed with enable. irq_line_o carries the masked state, and irq_o is high when any bit of it is set.
- R7: With filtering on for a line, a new pin level reaches the detector only after DB_CYCLES consecutive stable synchronized samples (level visible after edge 2+DB_CYCLES). Shorter pulses are dropped. Unfiltered lines are unaffected.
- R8: Changing a sense bit while the line is stable creates no edge event.
- R9: A write to the mode or sense register clears the edge flag of each line whose bit changes. Other lines keep their flags.
- R10: Acknowledge writes have no effect on lines in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register select |
| wdata_i | input | LINES | Write data |
| rdata_o | output | LINES | Read data for addr_i |
| pins_i | input | LINES | Asynchronous pin inputs |
| irq_line_o | output | LINES | Per-line masked request |
| irq_o | output | 1 | Combined request |

## Verification
The detector is driven with static pin levels under mixed sense bits, which separates active-high from active-low level sensing. It also gets rising and falling transitions across lines with opposite senses, which shows that only the chosen direction is flagged and that the flag stays set. Sense flips on steady pins, done both across all lines and in a both-edge acknowledge sequence, separate a detector that watches input history from one that compares the input with the sense bit. Filtered and unfiltered lines receive the same short pulse and the same long step, which confirms both the rejection and the exact acceptance delay.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_TRIG  = 5'h00;
  localparam logic [ADDR_W-1:0] A_POL   = 5'h04;
  localparam logic [ADDR_W-1:0] A_ACK   = 5'h08;
  localparam logic [ADDR_W-1:0] A_EN    = 5'h0C;
  localparam logic [ADDR_W-1:0] A_MSTAT = 5'h10;
  localparam logic [ADDR_W-1:0] A_RSTAT = 5'h14;
  localparam logic [ADDR_W-1:0] A_DBNC  = 5'h18;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LINES-1:0]  wdata_i,
  input  logic [LINES-1:0]  raw_i,
  input  logic [LINES-1:0]  masked_i,
  output logic [LINES-1:0]  trig_o,
  output logic [LINES-1:0]  pol_o,
  output logic [LINES-1:0]  en_o,
  output logic [LINES-1:0]  db_o,
  output logic [LINES-1:0]  ack_o,
  output logic [LINES-1:0]  chg_o,
  output logic [LINES-1:0]  rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o <= '0;
      pol_o  <= '0;
      en_o   <= '0;
      db_o   <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_TRIG:  trig_o <= wdata_i;
        A_POL:   pol_o  <= wdata_i;
        A_EN:    en_o   <= wdata_i;
        A_DBNC:  db_o   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign ack_o = (wr_i && addr_i == A_ACK) ? wdata_i : '0;

  // lines whose trigger configuration is being changed this cycle
  always_comb begin
    chg_o = '0;
    if (wr_i && addr_i == A_TRIG) chg_o = wdata_i ^ trig_o;
    if (wr_i && addr_i == A_POL)  chg_o = wdata_i ^ pol_o;
  end

  always_comb begin
    case (addr_i)
      A_TRIG:  rdata_o = trig_o;
      A_POL:   rdata_o = pol_o;
      A_EN:    rdata_o = en_o;
      A_MSTAT: rdata_o = masked_i;
      A_RSTAT: rdata_o = raw_i;
      A_DBNC:  rdata_o = db_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int LINES     = 8,
  parameter int DB_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] pins_i,
  input  logic [LINES-1:0] db_i,
  output logic [LINES-1:0] qual_o
);
  localparam int CNT_W = (DB_CYCLES < 2) ? 1 : $clog2(DB_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             s1_q, s2_q, flt_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        flt_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        s1_q <= pins_i[g];
        s2_q <= s1_q;
        // filter tracks the input while bypassed so enabling causes no step
        if (!db_i[g] || s2_q == flt_q) begin
          flt_q <= s2_q;
          cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
          flt_q <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign qual_o[g] = db_i[g] ? flt_q : s2_q;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int LINES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] qual_i,
  input  logic [LINES-1:0] trig_i,
  input  logic [LINES-1:0] pol_i,
  input  logic [LINES-1:0] ack_i,
  input  logic [LINES-1:0] chg_i,
  output logic [LINES-1:0] hit_o,
  output logic [LINES-1:0] latch_o,
  output logic [LINES-1:0] raw_o
);
  logic [LINES-1:0] prev_q, rise, fall, latch_d;

  assign rise  = qual_i & ~prev_q;
  assign fall  = ~qual_i & prev_q;
  assign hit_o = trig_i & ((pol_i & rise) | (~pol_i & fall));

  // new edge beats acknowledge; config change beats both
  assign latch_d = trig_i & ((latch_o & ~(ack_i | chg_i)) | (hit_o & ~chg_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      latch_o <= '0;
    end else begin
      prev_q  <= qual_i;
      latch_o <= latch_d;
    end
  end

  assign raw_o = (trig_i & latch_o) | (~trig_i & ~(qual_i ^ pol_i));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int LINES     = 8,
  parameter int DB_CYCLES = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic [gpio_irq_pkg::ADDR_W-1:0] addr_i,
  input  logic [LINES-1:0]                wdata_i,
  output logic [LINES-1:0]                rdata_o,
  input  logic [LINES-1:0]                pins_i,
  output logic [LINES-1:0]                irq_line_o,
  output logic                            irq_o
);
  logic [LINES-1:0] trig_q, pol_q, en_q, db_q, ack, chg;
  logic [LINES-1:0] qual, edge_hit, latch_q, raw, masked;

  gpio_irq_regs #(.LINES(LINES)) i_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .raw_i(raw), .masked_i(masked),
    .trig_o(trig_q), .pol_o(pol_q), .en_o(en_q), .db_o(db_q),
    .ack_o(ack), .chg_o(chg), .rdata_o
  );

  gpio_irq_filter #(.LINES(LINES), .DB_CYCLES(DB_CYCLES)) i_filter (
    .clk_i, .rst_ni, .pins_i, .db_i(db_q), .qual_o(qual)
  );

  gpio_irq_detect #(.LINES(LINES)) i_detect (
    .clk_i, .rst_ni, .qual_i(qual), .trig_i(trig_q), .pol_i(pol_q),
    .ack_i(ack), .chg_i(chg), .hit_o(edge_hit), .latch_o(latch_q), .raw_o(raw)
  );

  assign masked     = raw & en_q;
  assign irq_line_o = masked;
  assign irq_o      = |masked;
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [LINES-1:0]  wdata_i,
  input logic [LINES-1:0]  trig_q,
  input logic [LINES-1:0]  pol_q,
  input logic [LINES-1:0]  en_q,
  input logic [LINES-1:0]  latch_q,
  input logic [LINES-1:0]  edge_hit,
  input logic [LINES-1:0]  irq_line_o,
  input logic              irq_o
);
  always @(posedge clk_i) begin
    if (rst_ni === 1'b0) begin
      assert_reset_quiet_R1: assert (irq_o == 1'b0 && latch_q == '0 && en_q == '0);
    end
  end

  assert_sticky_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (($past(latch_q) & ~latch_q) == '0));

  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_ACK) |=> ((latch_q & $past(wdata_i & ~edge_hit)) == '0));

  assert_masked_by_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_line_o & ~en_q) == '0);

  assert_pol_change_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_POL) |=> ((latch_q & $past(wdata_i ^ pol_q)) == '0));

  assert_trig_change_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_TRIG) |=> ((latch_q & $past(wdata_i ^ trig_q)) == '0));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.LINES(LINES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .trig_q(trig_q), .pol_q(pol_q), .en_q(en_q), .latch_q(latch_q),
  .edge_hit(edge_hit), .irq_line_o(irq_line_o), .irq_o(irq_o)
);

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/1ps
module test_gpio_irq_unit;
  localparam int DB = 4;
  localparam logic [4:0] RT = 5'h00, RP = 5'h04, RA = 5'h08, RE = 5'h0C,
                         RM = 5'h10, RR = 5'h14, RD = 5'h18;

  logic       clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
  logic [4:0] addr = RR;
  logic [7:0] wdata = '0, pins = '0, rdata, irq_line;
  logic       irq;
  int n_cmp = 0, n_bad = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  gpio_irq_unit #(.LINES(8), .DB_CYCLES(DB)) i_gpio_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pins_i(pins), .irq_line_o(irq_line), .irq_o(irq)
  );

  // behavioural reference model
  bit [7:0] m_trig, m_pol, m_en, m_db, m_flag, m_prev, m_s1, m_s2, m_flt;
  int m_cnt [8];

  function automatic bit m_q(int i);
    return m_db[i] ? m_flt[i] : m_s2[i];
  endfunction

  function automatic bit [7:0] m_raw();
    bit [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = m_trig[i] ? m_flag[i] : (m_pol[i] ? m_q(i) : !m_q(i));
    return r;
  endfunction

  function automatic bit [7:0] m_read(logic [4:0] a);
    case (a)
      RT: return m_trig;
      RP: return m_pol;
      RE: return m_en;
      RM: return m_raw() & m_en;
      RR: return m_raw();
      RD: return m_db;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_trig = 0; m_pol = 0; m_en = 0; m_db = 0; m_flag = 0;
      m_prev = 0; m_s1 = 0; m_s2 = 0; m_flt = 0;
      for (int i = 0; i < 8; i++) m_cnt[i] = 0;
    end else begin
      bit [7:0] chg, ack, nflag, nprev, nflt;
      chg = 0; ack = 0;
      if (wr && addr == RT) chg = wdata ^ m_trig;
      if (wr && addr == RP) chg = wdata ^ m_pol;
      if (wr && addr == RA) ack = wdata;
      for (int i = 0; i < 8; i++) begin
        bit q, hit;
        q = m_q(i);
        hit = m_trig[i] && (m_pol[i] ? (q && !m_prev[i]) : (!q && m_prev[i]));
        nflag[i] = m_trig[i] && ((m_flag[i] && !ack[i] && !chg[i]) || (hit && !chg[i]));
        nprev[i] = q;
        nflt[i] = m_flt[i];
        if (!m_db[i] || m_s2[i] == m_flt[i]) begin
          nflt[i] = m_s2[i]; m_cnt[i] = 0;
        end else if (m_cnt[i] == DB - 1) begin
          nflt[i] = m_s2[i]; m_cnt[i] = 0;
        end else m_cnt[i]++;
      end
      m_flag = nflag; m_prev = nprev; m_flt = nflt;
      m_s2 = m_s1; m_s1 = pins;
      if (wr) case (addr)
        RT: m_trig = wdata;
        RP: m_pol = wdata;
        RE: m_en = wdata;
        RD: m_db = wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (started && rst_n) begin
      chk("R6 irq_line_o vs model", int'(irq_line), int'(m_raw() & m_en));
      chk("R6 irq_o vs model", int'(irq), int'((m_raw() & m_en) != 0));
      chk("R2 rdata vs model", int'(rdata), int'(m_read(addr)));
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(logic [4:0] a, logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0; addr = RR;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
    addr = RR;
  endtask

  task automatic expect_reg(string tag, logic [4:0] a, logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    chk(tag, int'(v), int'(e));
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    started = 1;
    repeat (3) @(negedge clk);
    chk("R1 irq_o in reset", int'(irq), 0);
    chk("R1 irq_line_o in reset", int'(irq_line), 0);
    #1 rst_n = 1'b1;
    idle(3);
    expect_reg("R1 mode reg reset", RT, 8'h00);
    expect_reg("R1 sense reg reset", RP, 8'h00);
    expect_reg("R1 enable reg reset", RE, 8'h00);
    expect_reg("R1 filter reg reset", RD, 8'h00);
    expect_reg("R1 unmasked active-low level", RR, 8'hFF);
    expect_reg("R2 ack reads zero", RA, 8'h00);

    // R3 level sensing with mixed senses
    wr_reg(RE, 8'hFF);
    wr_reg(RP, 8'h0F);
    pins = 8'h05;
    idle(1);
    expect_reg("R3 level before sync delay", RR, 8'hF0);
    idle(1);
    expect_reg("R3 level mixed senses", RR, 8'hF5);
    expect_reg("R6 masked equals raw with all enabled", RM, 8'hF5);

    // R4 edge sensing
    pins = 8'h00;
    idle(4);
    wr_reg(RT, 8'hFF);
    idle(4);
    expect_reg("R4 no edge on steady pins", RR, 8'h00);
    pins = 8'h13;
    idle(2);
    expect_reg("R4 edge not yet latched", RR, 8'h00);
    idle(1);
    expect_reg("R4 rising edges latched", RR, 8'h03);
    pins = 8'h00;
    idle(4);
    expect_reg("R4 falling edge added, flags sticky", RR, 8'h13);

    // R5 acknowledge
    wr_reg(RA, 8'h01);
    expect_reg("R5 ack clears only line 0", RR, 8'h12);
    wr_reg(RA, 8'h00);
    expect_reg("R5 zero ack no effect", RR, 8'h12);

    // R6 enable masking
    wr_reg(RE, 8'h10);
    expect_reg("R6 masked state", RM, 8'h10);
    chk("R6 irq_line_o", int'(irq_line), 8'h10);
    chk("R6 irq_o high", int'(irq), 1);
    wr_reg(RE, 8'h00);
    chk("R6 irq_o low when disabled", int'(irq), 0);
    expect_reg("R6 unmasked unaffected by enable", RR, 8'h12);
    wr_reg(RE, 8'hFF);

    // R9 config change clears changed lines only
    wr_reg(RP, 8'h1F);
    expect_reg("R9 sense change clears line 4 only", RR, 8'h02);
    wr_reg(RT, 8'hFD);
    expect_reg("R9 mode change clears line 1", RR, 8'h00);
    wr_reg(RT, 8'hFF);
    expect_reg("R9 back to edge, no flag", RR, 8'h00);

    // R8 sense flips on steady pins, then both-edge sequence
    wr_reg(RP, 8'h00);
    idle(4);
    expect_reg("R8 flip to falling gives no event", RR, 8'h00);
    wr_reg(RP, 8'hFF);
    idle(4);
    expect_reg("R8 flip to rising gives no event", RR, 8'h00);
    pins = 8'h80;
    idle(4);
    expect_reg("R4 line 7 rising", RR, 8'h80);
    wr_reg(RA, 8'h80);
    wr_reg(RP, 8'h7F);
    idle(4);
    expect_reg("R8 re-arm for falling, no false edge", RR, 8'h00);
    pins = 8'h00;
    idle(4);
    expect_reg("R8 falling edge after re-arm", RR, 8'h80);

    // R10 ack on level lines
    wr_reg(RT, 8'h00);
    expect_reg("R10 level low on line 7 sense 0", RR, 8'h80);
    wr_reg(RP, 8'hFF);
    pins = 8'h01;
    idle(2);
    expect_reg("R3 level high", RR, 8'h01);
    wr_reg(RA, 8'hFF);
    expect_reg("R10 ack ignored on level lines", RR, 8'h01);

    // R7 filter
    pins = 8'h00;
    wr_reg(RD, 8'h01);
    idle(8);
    expect_reg("R7 filtered idle", RR, 8'h00);
    pins = 8'h03;
    idle(2);
    expect_reg("R7 short pulse: unfiltered passes, filtered held", RR, 8'h02);
    pins = 8'h00;
    idle(10);
    expect_reg("R7 short pulse rejected", RR, 8'h00);
    pins = 8'h01;
    idle(DB);
    expect_reg("R7 level not yet accepted", RR, 8'h00);
    idle(2);
    expect_reg("R7 level accepted after stable window", RR, 8'h01);

    idle(4);
    started = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule